// File: doc/BRIEF.md
# Backplane Bus Slave Register Bank

This block is one endpoint on a shared parallel backplane bus. A single master drives every transfer, so the endpoint contains no arbitration and raises no interrupts. The master finds out what a slave holds only by reading it. Each endpoint keeps thirty-two 64-bit general registers. The master can write these registers and read them back.

Every endpoint uses the same logic. An endpoint learns its own address from a slot-identity input and a device-identity input, and it captures both while reset is held. Writes can reach one endpoint, every device in one slot, or every endpoint on the bus. Reads work only through an exact unicast address. The shared data bus is modelled as a data output plus a separate output enable. An endpoint raises the enable only in the cycle that carries its own read data, so that two endpoints never drive the bus at the same time.

A small state machine controls the read side. It has two states. ST_IDLE means the bus is released. ST_DRIVE means the endpoint is presenting read data. The transitions are:

- IDLE_TO_DRIVE: an accepted read is seen in ST_IDLE.
- DRIVE_HOLD: another accepted read is seen in ST_DRIVE.
- DRIVE_TO_IDLE: no accepted read is seen in ST_DRIVE.

Top module: `bbs_slave`

## Requirements
- R1: During reset and straight after it, bus_oe is 0, bus_rdata is zero, and all 32 registers read back as zero.
- R2: Address fields are laid out as follows. The slot number is bits [15:11]. The device number is bits [10:8]. The register index is bits [4:0]. Bits [7:5] have no effect on decoding.
- R3: A write whose slot and device fields both equal the captured identity updates only the indexed register, and it takes effect at that clock edge.
- R4: A write whose slot field equals the captured slot and whose device field is 0 (group) updates the indexed register.
- R5: A write whose slot field is all ones (31) updates the indexed register, whatever the device field holds.
- R6: Any other write changes no register. This covers a different slot, and also the same slot with a different non-zero device.
- R7: A read strobe at an exact unicast address raises bus_oe on the next clock. In that cycle bus_rdata holds the register value from the strobe cycle. Back-to-back reads keep bus_oe high, and bus_oe falls one clock after the last strobe.
- R8: A read whose address is a group address, a broadcast address or a non-matching address never raises bus_oe.
- R9: Whenever bus_oe is 0, bus_rdata is all zeros.
- R10: The slot and device identities are sampled only while reset is asserted. Later changes on those inputs do not affect decoding.
- R11: If the write and read strobes are both high in the same cycle, the write is performed and the read is dropped, so bus_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; the identity inputs are sampled while it is low |
| slot_id | input | 5 | Slot number from the slot wiring |
| dev_id | input | 3 | Device-within-slot number, 1 to 6 |
| bus_addr | input | 16 | Shared address bus |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 64 | Write data from the master |
| bus_rdata | output | 64 | Read data toward the shared bus |
| bus_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The bench goes after the decode corners:

- A group write or a broadcast write whose device field holds a foreign number. A decoder that got this wrong would either miss these writes or let them leak to the wrong device.
- A read at a broadcast address. A design that enabled its output here would drive the bus at the same moment as every other slave.
- Identity pins that change after reset. A design that re-sampled them would start answering at a new address.
- Reads placed back to back, and a read strobe raised in the same cycle as a write. Here a wrong design would show a wrong cycle of latency, stale data, or a spurious drive enable.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRIVE = 1'b1
    } drv_state_e;

endpackage

// File: rtl/bbs_addr_decode.sv
module bbs_addr_decode #(
    parameter int ADDR_W = 16,
    parameter int SLOT_W = 5,
    parameter int DEV_W  = 3,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_sel,
    output logic              rd_sel,
    output logic [REG_W-1:0]  reg_idx
);

    localparam int SLOT_LSB = ADDR_W - SLOT_W;
    localparam int DEV_LSB  = SLOT_LSB - DEV_W;
    localparam logic [SLOT_W-1:0] SLOT_ALL = '1;
    localparam logic [DEV_W-1:0]  DEV_ALL  = '0;

    logic [SLOT_W-1:0] my_slot;
    logic [DEV_W-1:0]  my_dev;
    logic [SLOT_W-1:0] a_slot;
    logic [DEV_W-1:0]  a_dev;
    logic              slot_eq;
    logic              dev_eq;

    // Identity is latched while reset is low and frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            my_slot <= slot_id;
            my_dev  <= dev_id;
        end
    end

    always_comb begin
        a_slot  = addr[SLOT_LSB +: SLOT_W];
        a_dev   = addr[DEV_LSB +: DEV_W];
        reg_idx = addr[REG_W-1:0];
        slot_eq = (a_slot == my_slot);
        dev_eq  = (a_dev == my_dev);
        wr_sel  = (a_slot == SLOT_ALL) || (slot_eq && ((a_dev == DEV_ALL) || dev_eq));
        rd_sel  = slot_eq && dev_eq && (a_slot != SLOT_ALL) && (a_dev != DEV_ALL);
    end

    // R10
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(my_slot) && $stable(my_dev));

    // R8
    rd_not_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_slot == SLOT_ALL) |-> !rd_sel);

endmodule

// File: rtl/bbs_reg_bank.sv
module bbs_reg_bank #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (idx == REG_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_word = regs[idx];
    end

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/bbs_read_ctrl.sv
module bbs_read_ctrl
    import bbs_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] rd_word,
    output logic              oe,
    output logic [DATA_W-1:0] rdata
);

    drv_state_e state;
    drv_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = rd_hit ? ST_DRIVE : ST_IDLE;
            ST_DRIVE: nxt = rd_hit ? ST_DRIVE : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_hit) begin
            rdata <= rd_word;
        end else begin
            rdata <= '0;
        end
    end

    assign oe = (state == ST_DRIVE);

    // R7
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> oe);

    // R7
    oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> !oe);

endmodule

// File: rtl/bbs_slave.sv
module bbs_slave #(
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 32,
    parameter int SLOT_W   = 5,
    parameter int DEV_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe
);

    localparam int REG_W    = $clog2(NUM_REGS);
    localparam int SLOT_LSB = ADDR_W - SLOT_W;

    logic             wr_sel;
    logic             rd_sel;
    logic [REG_W-1:0] reg_idx;
    logic [DATA_W-1:0] rd_word;
    logic             we;
    logic             rd_hit;

    bbs_addr_decode #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W),
        .DEV_W  (DEV_W),
        .REG_W  (REG_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_id (slot_id),
        .dev_id  (dev_id),
        .addr    (bus_addr),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel),
        .reg_idx (reg_idx)
    );

    // A write in the same cycle wins over a read.
    assign we     = bus_wr && wr_sel;
    assign rd_hit = bus_rd && !bus_wr && rd_sel;

    bbs_reg_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .idx     (reg_idx),
        .wdata   (bus_wdata),
        .rd_word (rd_word)
    );

    bbs_read_ctrl #(
        .DATA_W (DATA_W)
    ) u_rctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hit  (rd_hit),
        .rd_word (rd_word),
        .oe      (bus_oe),
        .rdata   (bus_rdata)
    );

    // R9
    release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_rdata == '0));

    // R11
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(bus_rd && !bus_wr));

    // R8
    bcast_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr[SLOT_LSB +: SLOT_W] == '1)) |=> !bus_oe);

endmodule

// File: tb/bbs_slave_bench.sv
module bbs_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] MY_SLOT = 5'd5;
    localparam logic [2:0] MY_DEV  = 3'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  slot_id = MY_SLOT;
    logic [2:0]  dev_id = MY_DEV;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_oe;

    int checks = 0;
    int failures = 0;

    logic [63:0] model [32];
    logic [64:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bbs_slave u_bbs_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_id   (slot_id),
        .dev_id    (dev_id),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_oe    (bus_oe)
    );

    function automatic logic [15:0] mk(input logic [4:0] s, input logic [2:0] d,
                                       input logic [4:0] r, input logic [2:0] junk);
        return {s, d, junk, r};
    endfunction

    // Driver: one bus cycle, pushes what the next edge must produce.
    task automatic cyc(input logic w, input logic r, input logic [15:0] a,
                       input logic [63:0] d, input string tag);
        logic       s_ok;
        logic       wr_acc;
        logic       rd_acc;
        logic [4:0] s;
        logic [2:0] dv;
        @(negedge clk);
        bus_wr = w;
        bus_rd = r;
        bus_addr = a;
        bus_wdata = d;
        s = a[15:11];
        dv = a[10:8];
        s_ok = (s == MY_SLOT);
        wr_acc = w && ((s == 5'h1f) || (s_ok && (dv == 3'd0 || dv == MY_DEV)));
        rd_acc = r && !w && s_ok && (dv == MY_DEV);
        exp_q.push_back({rd_acc, rd_acc ? model[a[4:0]] : 64'h0});
        tag_q.push_back(tag);
        if (wr_acc) model[a[4:0]] = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 16'h0, 64'h0, "R9");
    endtask

    // Monitor: compares each cycle's result just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [64:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (bus_oe !== e[64] || bus_rdata !== e[63:0]) begin
                    failures++;
                    $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
                             t, bus_oe, bus_rdata, e[64], e[63:0]);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog (all requirements): run hung, actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        checks++;
        if (bus_oe !== 1'b0 || bus_rdata !== 64'h0) begin
            failures++;
            $display("FAIL R1: in reset oe=%0b data=%h expected oe=0 data=0", bus_oe, bus_rdata);
        end
        rst_n = 1'b1;
        // R10: identity pins move after reset and must be ignored.
        slot_id = 5'd7;
        dev_id = 3'd2;

        // R1: every register reads zero after reset.
        for (int i = 0; i < 32; i++) cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'(i), 3'd0), 64'h0, "R1");
        idle(1);

        // R3 unicast writes, then R7 back-to-back readback.
        for (int i = 0; i < 8; i++)
            cyc(1'b1, 1'b0, mk(MY_SLOT, MY_DEV, 5'(i), 3'd0), 64'hA5A5_0000_0000_0000 + 64'(i * 17), "R3");
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'(i), 3'd0), 64'h0, "R7");
        idle(2);

        // R4 group write; R5 broadcast with a foreign device field.
        cyc(1'b1, 1'b0, mk(MY_SLOT, 3'd0, 5'd8, 3'd0), 64'h1111_2222_3333_4444, "R4");
        cyc(1'b1, 1'b0, mk(5'h1f, 3'd5, 5'd9, 3'd0), 64'hFEDC_BA98_7654_3210, "R5");
        cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'd8, 3'd0), 64'h0, "R4");
        cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'd9, 3'd0), 64'h0, "R5");
        idle(1);

        // R6 and R10: writes that must not land.
        cyc(1'b1, 1'b0, mk(5'd4, MY_DEV, 5'd10, 3'd0), 64'hDEAD_0001, "R6");
        cyc(1'b1, 1'b0, mk(MY_SLOT, 3'd2, 5'd11, 3'd0), 64'hDEAD_0002, "R6");
        cyc(1'b1, 1'b0, mk(5'd7, 3'd2, 5'd12, 3'd0), 64'hDEAD_0003, "R10");
        cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'd10, 3'd0), 64'h0, "R6");
        cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'd11, 3'd0), 64'h0, "R6");
        cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'd12, 3'd0), 64'h0, "R10");
        cyc(1'b0, 1'b1, mk(5'd7, 3'd2, 5'd0, 3'd0), 64'h0, "R10");
        idle(1);

        // R2: bits [7:5] do not matter.
        cyc(1'b1, 1'b0, mk(MY_SLOT, MY_DEV, 5'd13, 3'd7), 64'h0BAD_F00D_1234_5678, "R2");
        cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'd13, 3'd5), 64'h0, "R2");
        idle(1);

        // R8: group, broadcast and foreign reads never drive.
        cyc(1'b0, 1'b1, mk(MY_SLOT, 3'd0, 5'd8, 3'd0), 64'h0, "R8");
        cyc(1'b0, 1'b1, mk(5'h1f, MY_DEV, 5'd8, 3'd0), 64'h0, "R8");
        cyc(1'b0, 1'b1, mk(5'd6, MY_DEV, 5'd8, 3'd0), 64'h0, "R8");
        cyc(1'b0, 1'b1, mk(MY_SLOT, 3'd4, 5'd8, 3'd0), 64'h0, "R8");
        idle(1);

        // R11: simultaneous strobes, then readback of the new value.
        cyc(1'b1, 1'b1, mk(MY_SLOT, MY_DEV, 5'd14, 3'd0), 64'h7777_8888_9999_AAAA, "R11");
        cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'd14, 3'd0), 64'h0, "R11");
        cyc(1'b0, 1'b1, mk(MY_SLOT, MY_DEV, 5'd31, 3'd0), 64'h0, "R7");
        idle(3);

        while (exp_q.size() > 0) @(posedge clk);
        #5;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule